// File: doc/BRIEF.md
# Three-Tap Vertical Flicker Filter

This block smooths interlaced graphics vertically, one pixel at a time. Each cycle it may accept three vertically aligned ARGB pixels: the one from the line above, the one from the current line and the one from the line below. It returns a single pixel whose colour channels, and optionally its alpha channel, are a weighted blend of the three. The line buffers that deliver the aligned rows sit upstream, and the timing generator that marks field boundaries sits alongside.

The weight set is chosen by a 4-bit selector. Every supported set sums to one and is expressed in sixteenths, so each channel is computed with shifts and adds and then rounded to nearest. New selector and enable values are staged. An update request arms a pending flag, and the settings present on the inputs are adopted at the next field start. Unsupported selector codes fall back to pass-through and raise a sticky flag.

Top module: `vflicker_filter`

## Requirements
- R1: After reset, `pix_vld_o` and `rsvd_sel_o` are 0, `pix_o` is 0, and the active configuration is pass-through (filter off), so any pixel is output equal to its middle input.
- R2: Selector 4'b0000 uses weights 0, 16, 0 (sixteenths, top/middle/bottom), and the output equals the middle pixel.
- R3: Selector 4'b0001 uses weights 1, 14, 1 sixteenths.
- R4: Selector 4'b0010 uses weights 2, 12, 2 sixteenths.
- R5: Selector 4'b0100 uses weights 4, 8, 4 sixteenths, and selector 4'b0101 uses weights 5, 6, 5 sixteenths.
- R6: With the filter enable clear, the output pixel equals the middle pixel whatever the selector is.
- R7: Alpha is bits [31:24]. It is filtered only when both the filter enable and the alpha enable are set. Otherwise it equals the middle pixel's alpha, while the colour channels follow the filter enable.
- R8: Each 8-bit channel (bits [31:24], [23:16], [15:8], [7:0]) is computed on its own as (weighted sum in sixteenths + 8) >> 4, so an exact half rounds up. The result is clamped to 255, and the weighted sum never exceeds 255*16.
- R9: Selector codes other than 0000, 0001, 0010, 0100 and 0101 act as pass-through. `rsvd_sel_o` rises when such a code is adopted and stays set until reset.
- R10: `pix_vld_o` is `pix_vld_i` delayed by exactly two clock cycles, and it carries the pixel presented with that input.
- R11: `cfg_update_i` arms a pending update. On the first cycle with `field_start_i` high while an update is pending, or while `cfg_update_i` is also high, the values on `wsel_i`, `filt_en_i` and `alpha_en_i` become active and the pending update is cleared. At all other times the active configuration holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_vld_i | input | 1 | Input pixel triple valid |
| pix_top_i | input | 32 | ARGB pixel from the line above |
| pix_mid_i | input | 32 | ARGB pixel from the current line |
| pix_bot_i | input | 32 | ARGB pixel from the line below |
| wsel_i | input | 4 | Staged weight selector |
| filt_en_i | input | 1 | Staged filter enable |
| alpha_en_i | input | 1 | Staged alpha filter enable |
| cfg_update_i | input | 1 | Arms a pending configuration update |
| field_start_i | input | 1 | Frame or field start strobe |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_o | output | 32 | Filtered ARGB pixel |
| rsvd_sel_o | output | 1 | Sticky flag: a reserved selector code was adopted |

## Verification
The bench builds the block with its default parameters: 8-bit channels and four channels per pixel, with the alpha channel in the top byte. These values make the full-scale corner reachable, where every input channel is 255 and the clamp boundary is hit exactly. They also give the alpha lane its own independent path, so the alpha enable can be told apart from the colour channels. Hand-computed vectors cover exact-half rounding and each weight set, and directed tests cover staged configuration and the reserved-code flag.

// File: rtl/vff_pkg.sv
package vff_pkg;
  localparam int unsigned FRAC_W = 4;  // weights are in sixteenths

  typedef enum logic [3:0] {
    WSEL_PASS = 4'b0000,
    WSEL_1_14 = 4'b0001,
    WSEL_2_12 = 4'b0010,
    WSEL_4_8  = 4'b0100,
    WSEL_5_6  = 4'b0101
  } wsel_e;

  typedef struct packed {
    logic [3:0] sel;
    logic       filt_en;
    logic       alpha_en;
  } cfg_t;

  function automatic logic sel_is_rsvd(input logic [3:0] s);
    case (s)
      WSEL_PASS, WSEL_1_14, WSEL_2_12, WSEL_4_8, WSEL_5_6: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/vff_cfg.sv
module vff_cfg
  import vff_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] wsel_i,
  input  logic       filt_en_i,
  input  logic       alpha_en_i,
  input  logic       cfg_update_i,
  input  logic       field_start_i,
  output cfg_t       cfg_o,
  output logic       rsvd_o
);
  cfg_t cfg_q;
  logic pend_q;
  logic rsvd_q;
  logic load;

  assign load = field_start_i && (pend_q || cfg_update_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      rsvd_q <= 1'b0;
    end else begin
      pend_q <= load ? 1'b0 : (pend_q | cfg_update_i);
      if (load) begin
        cfg_q.sel      <= wsel_i;
        cfg_q.filt_en  <= filt_en_i;
        cfg_q.alpha_en <= alpha_en_i;
        if (sel_is_rsvd(wsel_i)) rsvd_q <= 1'b1;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign rsvd_o = rsvd_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> $stable(cfg_q)); // R11
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_start_i && pend_q && !cfg_update_i) |=> !pend_q); // R11
  AST_RSVD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_q |=> rsvd_q); // R9
endmodule

// File: rtl/vff_chan.sv
module vff_chan
  import vff_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic            s1_vld_i,
  input  logic [3:0]      code_i,
  input  logic [CH_W-1:0] top_i,
  input  logic [CH_W-1:0] mid_i,
  input  logic [CH_W-1:0] bot_i,
  output logic [CH_W-1:0] pix_o
);
  localparam int unsigned SUM_W = CH_W + FRAC_W + 1;
  localparam logic [SUM_W-1:0] CH_MAX  = SUM_W'((1 << CH_W) - 1);
  localparam logic [SUM_W-1:0] SUM_MAX = CH_MAX << FRAC_W;
  localparam logic [SUM_W-1:0] HALF    = SUM_W'(1 << (FRAC_W - 1));

  logic [SUM_W-1:0] outer, mid, sum_d, sum_q, rnd, quo;
  logic [CH_W-1:0]  pix_q;

  assign outer = SUM_W'(top_i) + SUM_W'(bot_i);
  assign mid   = SUM_W'(mid_i);

  always_comb begin
    case (wsel_e'(code_i))
      WSEL_1_14: sum_d = outer + (mid << 4) - (mid << 1);
      WSEL_2_12: sum_d = (outer << 1) + (mid << 3) + (mid << 2);
      WSEL_4_8:  sum_d = (outer << 2) + (mid << 3);
      WSEL_5_6:  sum_d = (outer << 2) + outer + (mid << 2) + (mid << 1);
      default:   sum_d = mid << 4;
    endcase
  end

  assign rnd = sum_q + HALF;
  assign quo = rnd >> FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      pix_q <= '0;
    end else begin
      if (vld_i)    sum_q <= sum_d;
      if (s1_vld_i) pix_q <= (quo > CH_MAX) ? CH_MAX[CH_W-1:0] : quo[CH_W-1:0];
    end
  end

  assign pix_o = pix_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_i |-> (sum_q <= SUM_MAX)); // R8
endmodule

// File: rtl/vflicker_filter.sv
module vflicker_filter
  import vff_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned NUM_CH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_vld_i,
  input  logic [CH_W*NUM_CH-1:0] pix_top_i,
  input  logic [CH_W*NUM_CH-1:0] pix_mid_i,
  input  logic [CH_W*NUM_CH-1:0] pix_bot_i,
  input  logic [3:0]             wsel_i,
  input  logic                   filt_en_i,
  input  logic                   alpha_en_i,
  input  logic                   cfg_update_i,
  input  logic                   field_start_i,
  output logic                   pix_vld_o,
  output logic [CH_W*NUM_CH-1:0] pix_o,
  output logic                   rsvd_sel_o
);
  localparam int unsigned ALPHA_CH = NUM_CH - 1;

  cfg_t       cfg;
  logic       rsvd;
  logic       s1_vld_q, s2_vld_q;
  logic       col_on, alpha_on;
  logic [3:0] col_code, alpha_code;

  vff_cfg u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wsel_i        (wsel_i),
    .filt_en_i     (filt_en_i),
    .alpha_en_i    (alpha_en_i),
    .cfg_update_i  (cfg_update_i),
    .field_start_i (field_start_i),
    .cfg_o         (cfg),
    .rsvd_o        (rsvd)
  );

  // reserved codes fall back to pass-through
  assign col_on     = cfg.filt_en && !sel_is_rsvd(cfg.sel);
  assign alpha_on   = col_on && cfg.alpha_en;
  assign col_code   = col_on   ? cfg.sel : WSEL_PASS;
  assign alpha_code = alpha_on ? cfg.sel : WSEL_PASS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= pix_vld_i;
      s2_vld_q <= s1_vld_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vff_chan #(.CH_W(CH_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (pix_vld_i),
      .s1_vld_i (s1_vld_q),
      .code_i   ((c == ALPHA_CH) ? alpha_code : col_code),
      .top_i    (pix_top_i[c*CH_W +: CH_W]),
      .mid_i    (pix_mid_i[c*CH_W +: CH_W]),
      .bot_i    (pix_bot_i[c*CH_W +: CH_W]),
      .pix_o    (pix_o[c*CH_W +: CH_W])
    );
  end

  assign pix_vld_o  = s2_vld_q;
  assign rsvd_sel_o = rsvd;

  AST_VLD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_i |=> ##1 pix_vld_o); // R10
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_i |=> ##1 !pix_vld_o); // R10
  AST_RSVD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_is_rsvd(cfg.sel) |-> (col_code == WSEL_PASS && alpha_code == WSEL_PASS)); // R9
endmodule

// File: tb/vflicker_filter_tb_top.sv
module vflicker_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [31:0] top = '0, mid = '0, bot = '0;
  logic [3:0]  sel = '0;
  logic        en = 1'b0, aen = 1'b0, upd = 1'b0, fs = 1'b0;
  logic        vld_o, rsvd_o;
  logic [31:0] pix_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vflicker_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_vld_i(vld_i),
    .pix_top_i(top), .pix_mid_i(mid), .pix_bot_i(bot),
    .wsel_i(sel), .filt_en_i(en), .alpha_en_i(aen),
    .cfg_update_i(upd), .field_start_i(fs),
    .pix_vld_o(vld_o), .pix_o(pix_o), .rsvd_sel_o(rsvd_o)
  );

  // {sel, en, aen, top, mid, bot, expected}
  localparam logic [133:0] VEC [12] = '{
    {4'h0, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h12345678, 32'h00000000, 32'h12345678},
    {4'h1, 1'b1, 1'b1, 32'h00000000, 32'h04040404, 32'h00000000, 32'h04040404},
    {4'h1, 1'b1, 1'b0, 32'h10101010, 32'h00000000, 32'h10101010, 32'h00020202},
    {4'h2, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {4'h2, 1'b1, 1'b1, 32'h0000FF80, 32'h00000000, 32'h00000080, 32'h00002020},
    {4'h4, 1'b1, 1'b1, 32'h10203040, 32'h00000000, 32'h00000000, 32'h04080C10},
    {4'h5, 1'b1, 1'b1, 32'h01010101, 32'h00000000, 32'h01010101, 32'h01010101},
    {4'h5, 1'b1, 1'b1, 32'h00000000, 32'hFF00FF00, 32'h00000000, 32'h60006000},
    {4'h4, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h89ABCDEF, 32'h00000000, 32'h89ABCDEF},
    {4'h3, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h13579BDF, 32'hFFFFFFFF, 32'h13579BDF},
    {4'h4, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h7F000000, 32'hFFFFFFFF, 32'h7F808080},
    {4'h4, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h7F000000, 32'hFFFFFFFF, 32'hBF808080}
  };
  localparam string VTAG [12] = '{"R2", "R3 R8", "R3 R7", "R4 R8", "R4", "R5",
                                  "R5 R8", "R5", "R6", "R9", "R7", "R7 R8"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] s, input logic e, input logic a,
                         input logic u, input logic f);
    @(negedge clk);
    sel = s; en = e; aen = a; upd = u; fs = f;
    @(negedge clk);
    upd = 1'b0; fs = 1'b0;
  endtask

  task automatic send(input logic [31:0] t, input logic [31:0] m, input logic [31:0] b,
                      output logic [31:0] res, output logic v);
    @(negedge clk);
    vld_i = 1'b1; top = t; mid = m; bot = b;
    @(negedge clk);
    vld_i = 1'b0;
    @(negedge clk);
    res = pix_o; v = vld_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic        v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 vld", {31'd0, vld_o}, 32'd0);
    chk("R1 pix", pix_o, 32'd0);
    chk("R1 rsvd", {31'd0, rsvd_o}, 32'd0);
    rst_n = 1'b1;
    // R1: no config adopted yet, staged inputs ignored
    sel = 4'h4; en = 1'b1; aen = 1'b1;
    send(32'hFFFFFFFF, 32'h11223344, 32'hFFFFFFFF, r, v);
    chk("R1 passthru", r, 32'h11223344);
    // R10: latency two cycles
    @(negedge clk);
    vld_i = 1'b1; top = '0; mid = 32'hA5A5A5A5; bot = '0;
    @(negedge clk);
    vld_i = 1'b0;
    chk("R10 vld after 1", {31'd0, vld_o}, 32'd0);
    @(negedge clk);
    chk("R10 vld after 2", {31'd0, vld_o}, 32'd1);
    chk("R10 data", pix_o, 32'hA5A5A5A5);
    @(negedge clk);
    chk("R10 vld after 3", {31'd0, vld_o}, 32'd0);
    // R11: update armed only, no field start
    set_cfg(4'h4, 1'b1, 1'b1, 1'b1, 1'b0);
    send(32'h10203040, 32'h00000000, 32'h00000000, r, v);
    chk("R11 pending not applied", r, 32'h00000000);
    // R11: field start with earlier pending update applies current inputs
    set_cfg(4'h4, 1'b1, 1'b1, 1'b0, 1'b1);
    send(32'h10203040, 32'h00000000, 32'h00000000, r, v);
    chk("R11 applied at field start", r, 32'h04080C10);
    // R11: field start without pending keeps config
    set_cfg(4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    send(32'h10203040, 32'h00000000, 32'h00000000, r, v);
    chk("R11 no pending hold", r, 32'h04080C10);
    chk("R9 flag clear before reserved", {31'd0, rsvd_o}, 32'd0);
    // table walk (update and field start in the same cycle)
    for (int i = 0; i < 12; i++) begin
      set_cfg(VEC[i][133:130], VEC[i][129], VEC[i][128], 1'b1, 1'b1);
      send(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], r, v);
      chk(VTAG[i], r, VEC[i][31:0]);
      chk("R10 vld", {31'd0, v}, 32'd1);
    end
    // R9: sticky flag stays set after a legal code is adopted
    chk("R9 flag sticky", {31'd0, rsvd_o}, 32'd1);
    // R6: enable off ignores selector
    set_cfg(4'h2, 1'b0, 1'b1, 1'b1, 1'b1);
    send(32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, r, v);
    chk("R6 disabled", r, 32'h00000000);
    finish_run();
  end
endmodule